// File: doc/BRIEF.md
# Selectable-Timebase Counter with Watchdog Lock

This block is a free-running counter whose increments are gated by one timebase picked from several. The timebase can be a slow or fast division of the system clock, overflow pulses from a neighbouring timer, falling edges on an external count pin, every system clock, or a slow external oscillator level that has already been divided by eight. The two signals from outside the clock domain pass through synchronizers before they are used. When the counter wraps, it sets a sticky overflow flag. An interrupt request follows that flag whenever the interrupt enable is set.

An 8-bit mode register holds the settings: idle suspension, watchdog enable, watchdog lock, the 3-bit source code and the overflow interrupt enable. While the watchdog is enabled, the register accepts only one kind of write, a write that clears the watchdog enable. Once the lock bit is set, the watchdog cannot be cleared again until reset. A single output, `wd_mode`, tells a companion compare module to behave as a watchdog.

Top module: `tbase_counter`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x40, `count` is 0, and `ovf_flag` and `irq` are 0.
- R2: Mode register bits are [7] idle suspend, [6] watchdog enable, [5] lock, [4] unused, [3:1] source, [0] interrupt enable. While bit 6 is 1, a write with data bit 6 = 1 is ignored. A write with data bit 6 = 0 clears only bit 6 and leaves every other field unchanged (unless the register is locked).
- R3: While bit 6 is 0, a write loads bits 7, 5, 3:1 and 0. Bit 4 always reads 0.
- R4: Writing bit 5 = 1 sets the lock and also sets bit 6. From then until reset, bits 5 and 6 stay 1 whatever is written.
- R5: `wd_mode` equals mode bit 6 at all times.
- R6: Source 100 counts every clock, source 000 counts once per 12 clocks, and source 001 counts once per 4 clocks.
- R7: Source 010 counts once per single-cycle pulse on `t0_ovf`.
- R8: Source 011 counts once per high-to-low transition of `ext_cnt_in` after a two-flop synchronizer. Edges must be at least 4 clocks apart.
- R9: Source 101 counts once per low-to-high transition of the synchronized `xosc_div8` level.
- R10: Source codes 110 and 111 never count, so `count` holds its value.
- R11: With bit 7 = 1, no count is taken while `cpu_idle` is 1. With bit 7 = 0, `cpu_idle` has no effect.
- R12: A count taken at 0xFFFF wraps the counter to 0 and sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed, and a new wrap in the same cycle as the clear wins.
- R13: `irq` is 1 exactly when `ovf_flag` is 1 and mode bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_idle | input | 1 | Processor idle indication |
| t0_ovf | input | 1 | Single-cycle overflow pulse from a neighbouring timer |
| ext_cnt_in | input | 1 | Asynchronous external count pin, counted on falling edges |
| xosc_div8 | input | 1 | Asynchronous external oscillator level, pre-divided by eight |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| cfg_rdata | output | 8 | Mode register read value |
| ovf_clr | input | 1 | Clears the overflow flag |
| count | output | CNT_W | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| wd_mode | output | 1 | Watchdog mode request to the compare module |

## Verification
A register write is captured at the clock edge where `cfg_wr` is high, and `cfg_rdata` shows it right after that edge. The bench therefore reads back one falling edge after the strobe. A qualified count is visible one edge after its enable. Rates are checked as the exact change in `count` across a whole number of prescaler periods, so the phase of the free-running dividers does not matter. The two external inputs reach the counter two edges after they change. The bench waits several settling cycles after its last edge before it takes the difference. The wrap is checked on the exact edge, computed from the starting count: one cycle before the wrap and on the wrap cycle itself.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  typedef enum logic [2:0] {
    SRC_DIV_SLOW = 3'd0,
    SRC_DIV_FAST = 3'd1,
    SRC_T0       = 3'd2,
    SRC_EXT_PIN  = 3'd3,
    SRC_SYSCLK   = 3'd4,
    SRC_XOSC8    = 3'd5,
    SRC_RSV_A    = 3'd6,
    SRC_RSV_B    = 3'd7
  } src_e;

  typedef struct packed {
    logic       idle_sus;
    logic       wd_en;
    logic       wd_lock;
    logic       spare;
    logic [2:0] src;
    logic       ovf_ie;
  } mode_t;

  localparam logic [7:0] MODE_RESET = 8'h40;

  // Next mode register value after a write of wd to the current value cur.
  function automatic mode_t mode_after_write(mode_t cur, logic [7:0] wd);
    mode_t w;
    mode_t n;
    w = mode_t'(wd);
    n = cur;
    if (cur.wd_en) begin
      if (!cur.wd_lock && !w.wd_en) n.wd_en = 1'b0;
    end else begin
      n       = w;
      n.spare = 1'b0;
      if (w.wd_lock) n.wd_en = 1'b1;
    end
    return n;
  endfunction

  // Counts are suppressed while idle only when suspension is selected.
  function automatic logic idle_gate(logic idle_sus, logic cpu_idle);
    return !(idle_sus && cpu_idle);
  endfunction

endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                    phase_q <= phase_q + 1'b1;
  end

  assign tick = (phase_q == LAST);
endmodule

// File: rtl/tbase_edge_sync.sv
module tbase_edge_sync #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic pulse
);
  // sh[STAGES-1] is the last synchronizer flop, sh[STAGES] its history.
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = sh[STAGES] & ~sh[STAGES-1];
    end else begin : g_rise
      assign pulse = ~sh[STAGES] & sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tbase_mode_reg.sv
module tbase_mode_reg
  import tbase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output mode_t      mode
);
  mode_t mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mode_q <= mode_t'(MODE_RESET);
    else if (wr) mode_q <= mode_after_write(mode_q, wdata);
  end

  assign mode = mode_q;
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_idle,
  input  logic             t0_ovf,
  input  logic             ext_cnt_in,
  input  logic             xosc_div8,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             irq,
  output logic             wd_mode
);
  mode_t            mode;
  logic             tick_slow;
  logic             tick_fast;
  logic             ext_fall;
  logic             xosc_rise;
  logic             src_en;
  logic             cnt_step;
  logic             wrap_evt;
  logic [CNT_W-1:0] count_q;
  logic             flag_q;

  tbase_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .mode  (mode)
  );

  tbase_prescale #(.DIV(DIV_SLOW)) u_div_slow (
    .clk(clk), .rst_n(rst_n), .tick(tick_slow)
  );

  tbase_prescale #(.DIV(DIV_FAST)) u_div_fast (
    .clk(clk), .rst_n(rst_n), .tick(tick_fast)
  );

  tbase_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_ext_pin (
    .clk(clk), .rst_n(rst_n), .din(ext_cnt_in), .pulse(ext_fall)
  );

  tbase_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_xosc (
    .clk(clk), .rst_n(rst_n), .din(xosc_div8), .pulse(xosc_rise)
  );

  always_comb begin
    unique case (src_e'(mode.src))
      SRC_DIV_SLOW: src_en = tick_slow;
      SRC_DIV_FAST: src_en = tick_fast;
      SRC_T0:       src_en = t0_ovf;
      SRC_EXT_PIN:  src_en = ext_fall;
      SRC_SYSCLK:   src_en = 1'b1;
      SRC_XOSC8:    src_en = xosc_rise;
      default:      src_en = 1'b0;
    endcase
  end

  assign cnt_step = src_en && idle_gate(mode.idle_sus, cpu_idle);
  assign wrap_evt = cnt_step && (&count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (cnt_step) count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap_evt) flag_q <= 1'b1;
    else if (ovf_clr)  flag_q <= 1'b0;
  end

  assign count     = count_q;
  assign ovf_flag  = flag_q;
  assign irq       = flag_q & mode.ovf_ie;
  assign wd_mode   = mode.wd_en;
  assign cfg_rdata = mode;
endmodule

// File: rtl/tbase_counter_chk.sv
module tbase_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_idle,
  input logic             cfg_wr,
  input logic [7:0]       cfg_wdata,
  input logic [7:0]       cfg_rdata,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             irq,
  input logic             wd_mode,
  input logic             cnt_step
);
  AST_PROTECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_rdata[6] && cfg_wdata[6]) |=> $stable(cfg_rdata)); // R2
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[4] == 1'b0); // R3
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[5] |=> (cfg_rdata[5] && cfg_rdata[6])); // R4
  AST_WD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_mode == cfg_rdata[6]); // R5
  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_step && !(&count)) |=> count == $past(count) + 1'b1); // R6
  AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_step |=> $stable(count)); // R10
  AST_IDLE_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7] && cpu_idle) |-> !cnt_step); // R11
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_step && (&count)) |=> (ovf_flag && count == '0)); // R12
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R12
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (ovf_flag && cfg_rdata[0])); // R13
endmodule

bind tbase_counter tbase_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_idle  (cpu_idle),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .ovf_clr   (ovf_clr),
  .count     (count),
  .ovf_flag  (ovf_flag),
  .irq       (irq),
  .wd_mode   (wd_mode),
  .cnt_step  (cnt_step)
);

// File: tb/sim_tbase_counter.sv
`timescale 1ns/1ps
module sim_tbase_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_idle = 1'b0;
  logic        t0_ovf = 1'b0;
  logic        ext_cnt_in = 1'b1;
  logic        xosc_div8 = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        ovf_clr = 1'b0;
  logic [15:0] count;
  logic        ovf_flag;
  logic        irq;
  logic        wd_mode;

  always #2.5 clk = ~clk;

  tbase_counter u0 (
    .clk(clk), .rst_n(rst_n), .cpu_idle(cpu_idle), .t0_ovf(t0_ovf),
    .ext_cnt_in(ext_cnt_in), .xosc_div8(xosc_div8), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ovf_clr(ovf_clr),
    .count(count), .ovf_flag(ovf_flag), .irq(irq), .wd_mode(wd_mode)
  );

  typedef struct {
    string req;
    string what;
    int    exp;
    int    act;
  } item_t;

  item_t q[$];
  event  push_ev;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // Driver side: queue expected against observed
  task automatic expect_eq(string req, string what, int exp, int act);
    item_t it;
    it.req = req; it.what = what; it.exp = exp; it.act = act;
    q.push_back(it);
    -> push_ev;
  endtask

  // Monitor side: pop and compare
  task automatic drain();
    item_t it;
    while (q.size() > 0) begin
      it = q.pop_front();
      n_vec++;
      if (it.act != it.exp) begin
        n_bad++;
        $display("FAIL %s %s: actual 0x%0h expected 0x%0h", it.req, it.what, it.act, it.exp);
      end
    end
  endtask

  initial begin
    forever begin
      @(push_ev);
      #0.1;
      drain();
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      #1;
      drain();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c0;
    int c;
    run(3);
    expect_eq("R1", "rdata", 8'h40, int'(cfg_rdata));
    expect_eq("R1", "count", 0, int'(count));
    expect_eq("R1", "flag", 0, int'(ovf_flag));
    expect_eq("R1", "irq", 0, int'(irq));
    expect_eq("R5", "wd_mode reset", 1, int'(wd_mode));
    rst_n = 1'b1;

    // R2: protected writes
    wr(8'h4F);
    expect_eq("R2", "ignored write", 8'h40, int'(cfg_rdata));
    wr(8'h0E);
    expect_eq("R2", "clear only wd_en", 8'h00, int'(cfg_rdata));
    expect_eq("R5", "wd_mode cleared", 0, int'(wd_mode));

    // R3 / R10: full write, spare bit, reserved sources
    wr(8'h1F);
    expect_eq("R3", "load fields spare zero", 8'h0F, int'(cfg_rdata));
    c0 = int'(count);
    run(100);
    expect_eq("R10", "hold src 111", 0, int'(count) - c0);
    wr(8'h0D);
    c0 = int'(count);
    run(50);
    expect_eq("R10", "hold src 110", 0, int'(count) - c0);

    // R6: clock-derived rates
    wr(8'h09);
    c0 = int'(count);
    run(100);
    expect_eq("R6", "sysclk rate", 100, int'(count) - c0);
    wr(8'h01);
    c0 = int'(count);
    run(120);
    expect_eq("R6", "div12 rate", 10, int'(count) - c0);
    wr(8'h03);
    c0 = int'(count);
    run(120);
    expect_eq("R6", "div4 rate", 30, int'(count) - c0);

    // R7: timer overflow pulses
    wr(8'h05);
    c0 = int'(count);
    for (int i = 0; i < 7; i++) begin
      t0_ovf = 1'b1; run(1);
      t0_ovf = 1'b0; run(2);
    end
    run(2);
    expect_eq("R7", "t0 pulses", 7, int'(count) - c0);

    // R8: falling edges on the external pin
    wr(8'h07);
    c0 = int'(count);
    for (int i = 0; i < 5; i++) begin
      ext_cnt_in = 1'b0; run(2);
      ext_cnt_in = 1'b1; run(2);
    end
    run(6);
    expect_eq("R8", "pin falling edges", 5, int'(count) - c0);

    // R9: rising edges of the divided oscillator
    wr(8'h0B);
    c0 = int'(count);
    for (int i = 0; i < 6; i++) begin
      xosc_div8 = 1'b1; run(4);
      xosc_div8 = 1'b0; run(4);
    end
    run(6);
    expect_eq("R9", "xosc rising edges", 6, int'(count) - c0);

    // R11: idle suspension
    wr(8'h89);
    cpu_idle = 1'b1;
    run(1);
    c0 = int'(count);
    run(50);
    expect_eq("R11", "suspended in idle", 0, int'(count) - c0);
    wr(8'h09);
    c0 = int'(count);
    run(50);
    expect_eq("R11", "idle ignored", 50, int'(count) - c0);
    cpu_idle = 1'b0;

    // R12 / R13: wrap and interrupt
    wr(8'h0F);
    c = int'(count);
    wr(8'h09);
    run(65536 - c - 2);
    expect_eq("R12", "count before wrap", 16'hFFFE, int'(count));
    expect_eq("R12", "flag before wrap", 0, int'(ovf_flag));
    run(2);
    expect_eq("R12", "count wrapped", 0, int'(count));
    expect_eq("R12", "flag set", 1, int'(ovf_flag));
    expect_eq("R13", "irq enabled", 1, int'(irq));
    wr(8'h0E);
    expect_eq("R12", "flag sticky", 1, int'(ovf_flag));
    expect_eq("R13", "irq masked", 0, int'(irq));
    wr(8'h0F);
    expect_eq("R13", "irq unmasked", 1, int'(irq));
    ovf_clr = 1'b1; run(1);
    ovf_clr = 1'b0;
    expect_eq("R12", "flag cleared", 0, int'(ovf_flag));
    expect_eq("R13", "irq after clear", 0, int'(irq));

    // R4: lock
    wr(8'h20);
    expect_eq("R4", "lock sets wd_en", 8'h60, int'(cfg_rdata));
    expect_eq("R5", "wd_mode locked", 1, int'(wd_mode));
    wr(8'h00);
    expect_eq("R4", "locked clear ignored", 8'h60, int'(cfg_rdata));
    wr(8'h80);
    expect_eq("R4", "locked write ignored", 8'h60, int'(cfg_rdata));

    run(2);
    finish_run();
  end
endmodule